// File: doc/BRIEF.md
# Programmable Watchdog Timer with Two-Step Refresh

This block is a supervisory timer for a small processor subsystem. A 15-bit up-counter advances at a slow rate taken from the system clock. A prescaler picks one of two rates: one step every `BASE_DIV` clocks, or one step every `BASE_DIV*SLOW_DIV` clocks. When the counter wraps from all ones to zero, the block pulses a reset request and records that the watchdog caused the reset. Software must therefore service the timer before that wrap.

Software reaches the block through a small write port with two registers: a reload register and a control register. A write of the confirm bit starts the timer. Once the timer is running, nothing software can do will stop it. Servicing is a two-write handshake: an arm write, and then a confirm write on the very next clock. The handshake loads the seven reload bits into the top of the counter, clears the low byte and restarts the prescaler. A halt input, driven high in the idle and power-down states, freezes the counter and the prescaler.

Top module: `prog_watchdog`

## Requirements
- R1: While `rst_n` is low, and once its synchronised release completes, the outputs read as follows: `wdt_count` zero, `wdt_running` low, `wdt_caused_rst` low and `wdt_rst_req` low.
- R2: The counter holds its value until a control write (`wr_sel`=1) with bit 1 (confirm) set. Writes to the reload register (`wr_sel`=0) do not start it. After a confirm write, `wdt_running` reads 1 from the next cycle.
- R3: Once `wdt_running` is 1, it drops only on a counter wrap or on an external reset. A control write of any other value, and any reload write, leaves it at 1.
- R4: A control write with bit 0 (arm) set, followed on the next clock by a control write with bit 1 set, is a refresh. After that second edge, `wdt_count` equals {reload[6:0], 8'h00} and the prescaler phase restarts from zero.
- R5: A confirm write that does not come on the clock directly after an arm write does not reload the counter. This covers an idle cycle or any other write between the two, and also arm-only writes.
- R6: When reload bit 7 is 0, the counter steps once every `BASE_DIV` clocks. After a refresh at edge 0, `wdt_count` after k further edges is the loaded value plus floor(k/`BASE_DIV`).
- R7: When reload bit 7 is 1, the counter steps once every `BASE_DIV*SLOW_DIV` clocks, with the same floor rule as in R6.
- R8: While `halt` is 1, the counter and the prescaler phase hold. Counting resumes from the held phase when `halt` drops.
- R9: A step from 15'h7FFF raises `wdt_rst_req` for exactly one cycle. On that cycle `wdt_count` is zero and `wdt_running` is low. With reload value r (7 bits) and step period P, the pulse starts (32768 - 256*r)*P clocks after the refresh edge.
- R10: `wdt_caused_rst` is set by the wrap and stays set while the counter is stopped and restarted. Only an external reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asserted asynchronously |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_sel | input | 1 | 0 selects the reload register, 1 selects the control register |
| wr_data | input | 8 | Write data. Reload: bit 7 is the slow-rate select, bits 6..0 are the reload value. Control: bit 0 is arm, bit 1 is confirm/start |
| halt | input | 1 | Freezes counting while high (idle or power-down) |
| wdt_rst_req | output | 1 | One-cycle reset request on counter wrap |
| wdt_running | output | 1 | Timer has been started and not yet reset |
| wdt_caused_rst | output | 1 | Sticky flag: last reset came from the watchdog |
| wdt_count | output | 15 | Present counter value |

## Verification
All register writes take effect on the clock edge that samples them. Their results can therefore be read half a cycle later: the start, the refresh load and the loss of a refresh that missed its slot. Counter steps fall exactly on every P-th edge after a refresh. The reset pulse falls on edge (32768 - 256*r)*P, and the bench checks the cycle just before that edge and the cycle just after it.

The bench drives inputs and samples outputs only at falling edges. It counts every falling edge since the refresh and compares against floor(k/P), adding no edges while `halt` is high. The bench is built with small divider values, so that full wrap periods in both rates fit within the run.

// File: rtl/prog_wdt_pkg.sv
package prog_wdt_pkg;

  // Write target decode
  typedef enum logic {
    WSEL_RELOAD = 1'b0,
    WSEL_CTRL   = 1'b1
  } wdt_sel_e;

  // Control register bit positions decoded by the refresh logic
  localparam int unsigned CTL_ARM_BIT  = 0;
  localparam int unsigned CTL_CONF_BIT = 1;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic restart,
  input  logic slow_sel,
  output logic tick
);

  localparam int unsigned BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [BW-1:0] base_q, base_d;
  logic [SW-1:0] slow_q, slow_d;
  logic          base_wrap, slow_wrap;

  assign base_wrap = (base_q == BASE_LAST);
  assign slow_wrap = (slow_q == SLOW_LAST);
  assign tick      = run_en & base_wrap & (~slow_sel | slow_wrap);

  always_comb begin
    base_d = base_q;
    slow_d = slow_q;
    if (restart) begin
      base_d = '0;
      slow_d = '0;
    end else if (run_en) begin
      if (base_wrap) begin
        base_d = '0;
        slow_d = slow_wrap ? '0 : slow_q + 1'b1;
      end else begin
        base_d = base_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      slow_q <= '0;
    end else begin
      base_q <= base_d;
      slow_q <= slow_d;
    end
  end

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !restart) |=> ($stable(base_q) && $stable(slow_q)));

  // R4
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (base_q == '0 && slow_q == '0));

endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl
  import prog_wdt_pkg::*;
#(
  parameter int unsigned REL_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wd_clr,
  output logic [REL_W-1:0]  reload_val,
  output logic              slow_sel,
  output logic              running,
  output logic              refresh
);

  logic [REL_W:0] reload_q, reload_d;
  logic           arm_q, arm_d;
  logic           run_q, run_d;
  logic           wr_ctl, wr_rel, conf_bit, arm_bit;

  assign wr_ctl   = wr_en & (wdt_sel_e'(wr_sel) == WSEL_CTRL);
  assign wr_rel   = wr_en & (wdt_sel_e'(wr_sel) == WSEL_RELOAD);
  assign conf_bit = wr_data[CTL_CONF_BIT];
  assign arm_bit  = wr_data[CTL_ARM_BIT];

  assign refresh    = wr_ctl & conf_bit & arm_q;
  assign reload_val = reload_q[REL_W-1:0];
  assign slow_sel   = reload_q[REL_W];
  assign running    = run_q;

  always_comb begin
    reload_d = reload_q;
    if (wr_rel) reload_d = wr_data[REL_W:0];
    arm_d = wr_ctl & arm_bit & ~wd_clr;
    run_d = run_q;
    if (wd_clr)                 run_d = 1'b0;
    else if (wr_ctl & conf_bit) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      arm_q    <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      arm_q    <= arm_d;
      run_q    <= run_d;
    end
  end

  // R3
  no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(wd_clr));

  // R5
  refresh_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> $past(wr_en && wr_sel && wr_data[CTL_ARM_BIT]));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned REL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             refresh,
  input  logic [REL_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             overflow
);

  localparam int unsigned LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign overflow = tick & (&cnt_q) & ~refresh;
  assign cnt      = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (refresh)   cnt_d = {reload_val, {LOW_W{1'b0}}};
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (cnt_q == {$past(reload_val), {LOW_W{1'b0}}}));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/prog_watchdog.sv
module prog_watchdog #(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned REL_W    = 7,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BASE_DIV = 12,
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              halt,
  output logic              wdt_rst_req,
  output logic              wdt_running,
  output logic              wdt_caused_rst,
  output logic [CNT_W-1:0]  wdt_count
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [REL_W-1:0] reload_val;
  logic             slow_sel, running, refresh, tick, overflow;
  logic             req_q, req_d, flag_q, flag_d;

  // Asynchronous assert, synchronised release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_ctl #(.REL_W(REL_W), .DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .wd_clr     (overflow),
    .reload_val (reload_val),
    .slow_sel   (slow_sel),
    .running    (running),
    .refresh    (refresh)
  );

  wdt_prescaler #(.BASE_DIV(BASE_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_en   (running & ~halt),
    .restart  (refresh | overflow),
    .slow_sel (slow_sel),
    .tick     (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (tick),
    .refresh    (refresh),
    .reload_val (reload_val),
    .cnt        (wdt_count),
    .overflow   (overflow)
  );

  always_comb begin
    req_d  = overflow;
    flag_d = flag_q | overflow;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      flag_q <= flag_d;
    end
  end

  assign wdt_rst_req    = req_q;
  assign wdt_running    = running;
  assign wdt_caused_rst = flag_q;

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R9
  req_state_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_rst_req |-> (!wdt_running && wdt_count == '0));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_caused_rst |=> wdt_caused_rst);

  // R10
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wdt_caused_rst) |-> wdt_rst_req);

endmodule

// File: tb/tb_prog_watchdog.sv
module tb_prog_watchdog;

  localparam int CLK_PERIOD = 10;
  localparam int BDIV = 3;
  localparam int SDIV = 4;
  localparam int MAX_CYC = 200000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [7:0]  wr_data;
  logic        halt;
  logic        wdt_rst_req;
  logic        wdt_running;
  logic        wdt_caused_rst;
  logic [14:0] wdt_count;

  int n_chk;
  int n_fail;
  bit done;

  prog_watchdog #(.BASE_DIV(BDIV), .SLOW_DIV(SDIV)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .wr_data        (wr_data),
    .halt           (halt),
    .wdt_rst_req    (wdt_rst_req),
    .wdt_running    (wdt_running),
    .wdt_caused_rst (wdt_caused_rst),
    .wdt_count      (wdt_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int step_period(bit slow);
    return slow ? BDIV * SDIV : BDIV;
  endfunction

  function automatic int exp_count(int base, int k, bit slow);
    return base + k / step_period(slow);
  endfunction

  function automatic int wrap_cycles(int rel, bit slow);
    return (32768 - 256 * rel) * step_period(slow);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic sel, logic [7:0] data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic do_refresh();
    bus_wr(1'b1, 8'h01);
    bus_wr(1'b1, 8'h02);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed   = $urandom(32'd1357);
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    wr_sel = 1'b0;
    wr_data = 8'h00;
    halt   = 1'b0;
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    wait_cyc(3);
    // R1: reset values while held
    check("R1 count", int'(wdt_count), 0);
    check("R1 running", int'(wdt_running), 0);
    check("R1 flag", int'(wdt_caused_rst), 0);
    check("R1 req", int'(wdt_rst_req), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 released count", int'(wdt_count), 0);

    // R2: idle until started
    wait_cyc(30);
    check("R2 idle count", int'(wdt_count), 0);
    bus_wr(1'b0, 8'h70);
    wait_cyc(30);
    check("R2 reload write no start", int'(wdt_running), 0);
    check("R2 reload write count", int'(wdt_count), 0);
    bus_wr(1'b1, 8'h02);
    check("R2 started", int'(wdt_running), 1);
    wait_cyc(3 * BDIV);
    check("R6 count after start", int'(wdt_count), 3);

    // R4 / R6: refresh and prescaler phase
    do_refresh();
    check("R4 refresh load", int'(wdt_count), 32'h7000);
    wait_cyc(BDIV - 1);
    check("R6 before first step", int'(wdt_count), 32'h7000);
    wait_cyc(1);
    check("R6 first step", int'(wdt_count), 32'h7001);

    // R5: confirm one cycle late
    do_refresh();
    bus_wr(1'b1, 8'h01);
    wait_cyc(1);
    bus_wr(1'b1, 8'h02);
    wait_cyc(6);
    check("R5 gap no reload", int'(wdt_count), exp_count(32'h7000, 9, 1'b0));

    // R5: other write between arm and confirm
    do_refresh();
    bus_wr(1'b1, 8'h01);
    bus_wr(1'b0, 8'h70);
    bus_wr(1'b1, 8'h02);
    wait_cyc(3);
    check("R5 interleaved no reload", int'(wdt_count), exp_count(32'h7000, 6, 1'b0));

    // R3: no write stops the timer
    do_refresh();
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b1, 8'hFC);
    bus_wr(1'b0, 8'h00);
    check("R3 still running", int'(wdt_running), 1);
    check("R5 arm-free writes no reload", int'(wdt_count), exp_count(32'h7000, 3, 1'b0));
    bus_wr(1'b0, 8'h70);

    // R8: halt freezes
    do_refresh();
    wait_cyc(4);
    check("R8 pre-halt", int'(wdt_count), exp_count(32'h7000, 4, 1'b0));
    halt = 1'b1;
    wait_cyc(50);
    check("R8 held", int'(wdt_count), exp_count(32'h7000, 4, 1'b0));
    halt = 1'b0;
    wait_cyc(2);
    check("R8 resumed phase", int'(wdt_count), exp_count(32'h7000, 6, 1'b0));

    // R9 / R10: wrap in fast mode
    bus_wr(1'b0, 8'h7F);
    do_refresh();
    wait_cyc(wrap_cycles(8'h7F, 1'b0) - 1);
    check("R9 no req before wrap", int'(wdt_rst_req), 0);
    check("R9 count at top", int'(wdt_count), 32'h7FFF);
    wait_cyc(1);
    check("R9 req on wrap", int'(wdt_rst_req), 1);
    check("R9 count cleared", int'(wdt_count), 0);
    check("R9 stopped", int'(wdt_running), 0);
    check("R10 flag set", int'(wdt_caused_rst), 1);
    wait_cyc(1);
    check("R9 single cycle", int'(wdt_rst_req), 0);
    wait_cyc(20);
    check("R2 stopped holds", int'(wdt_count), 0);
    check("R10 flag kept", int'(wdt_caused_rst), 1);

    // R7: slow mode, restart and wrap
    bus_wr(1'b0, 8'hFE);
    do_refresh();
    check("R7 restart running", int'(wdt_running), 1);
    check("R4 slow load", int'(wdt_count), 32'h7E00);
    wait_cyc(BDIV * SDIV - 1);
    check("R7 before slow step", int'(wdt_count), 32'h7E00);
    wait_cyc(1);
    check("R7 slow step", int'(wdt_count), 32'h7E01);
    wait_cyc(wrap_cycles(8'h7E, 1'b1) - BDIV * SDIV - 1);
    check("R9 slow no req early", int'(wdt_rst_req), 0);
    wait_cyc(1);
    check("R9 slow req", int'(wdt_rst_req), 1);
    check("R10 flag after restart", int'(wdt_caused_rst), 1);

    // R10: external reset clears the flag
    wait_cyc(2);
    rst_n = 1'b0;
    #1;
    check("R10 ext reset clears flag", int'(wdt_caused_rst), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 after ext reset flag", int'(wdt_caused_rst), 0);
    check("R1 after ext reset running", int'(wdt_running), 0);

    // Random reloads, rates, waits and halts
    for (int it = 0; it < 10; it++) begin
      int rel;
      bit slow;
      int k;
      int h;
      int base;
      rel  = 8'h40 + int'($urandom % 64);
      slow = bit'($urandom % 2);
      bus_wr(1'b0, {slow, 7'(rel)});
      do_refresh();
      base = rel * 256;
      check("R4 random load", int'(wdt_count), base);
      k = int'($urandom % 300);
      wait_cyc(k);
      check(slow ? "R7 random count" : "R6 random count",
            int'(wdt_count), exp_count(base, k, slow));
      h = 1 + int'($urandom % 20);
      halt = 1'b1;
      wait_cyc(h);
      check("R8 random halt", int'(wdt_count), exp_count(base, k, slow));
      halt = 1'b0;
      h = int'($urandom % 300);
      wait_cyc(h);
      check(slow ? "R7 random resume" : "R6 random resume",
            int'(wdt_count), exp_count(base, k + h, slow));
      check("R3 random running", int'(wdt_running), 1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule